// File: doc/BRIEF.md
# Four-Lane Sample Word Serializer

This block turns one set of parallel conversion results (one 12-bit word for each of four channels) into four serial lanes. It runs from a fast clock at twelve times the sample rate, so every lane carries exactly one bit in each fast-clock cycle and one whole word in each sample period. With the lanes it drives a frame clock at the sample rate and a bit clock at six times the sample rate. A receiver latches data on both edges of the bit clock and uses the rising frame edge to find the first bit of each word.

Results arrive as a valid strobe together with all four words. The block keeps the most recent set and moves it into the serializer only at a word boundary. When no new set has arrived, the previous words go out again. A mode input selects whether the most significant or the least significant bit goes first. The mode is taken at the word boundary and applies to all lanes. Every output is a single-ended logic-level model of the lane or clock that it stands for.

Top module: `adc_word_serializer`

## Requirements
- R1: The frame clock has a period of WORD_W fast cycles. It is high for the first WORD_W/2 slots of each word and low for the remaining slots.
- R2: Once running, the bit clock changes level on every fast cycle. It is high in even slots and low in odd slots, so each bit-clock half period carries one data bit.
- R3: Slot 0 of every word, which carries the first bit, is the cycle in which the frame clock rises, and the bit clock is high in that cycle.
- R4: With msb_first = 1, slot k of a lane carries bit WORD_W-1-k of that lane's word.
- R5: With msb_first = 0, slot k of a lane carries bit k of that lane's word.
- R6: msb_first is sampled only in the last slot of a word. A change during a word leaves that word's order unchanged, and the next word follows the new order.
- R7: A valid strobe in any slot, including the last slot, stores the four words. The stored set goes out starting with the next word, and the word in flight does not change. If several strobes arrive within one word, the latest one wins.
- R8: When no strobe arrives during a word, the next word repeats the previous words on every lane.
- R9: While rst is high, and in the first cycle after it falls, all lanes, the frame clock and the bit clock are low. The stored words are cleared to zero. The first word starts (slot 0, frame clock rising) one cycle after rst falls.
- R10: Lane g carries bits [g*WORD_W +: WORD_W] of in_words. All lanes share the slot timing and the bit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twelve times the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe marking a new set of words on in_words |
| in_words | input | LANES*WORD_W | Parallel words, lane g at bits [g*WORD_W +: WORD_W] |
| msb_first | input | 1 | 1: most significant bit first; 0: least significant bit first |
| lane_out | output | LANES | Serial data lanes, one bit per fast cycle |
| frame_clk | output | 1 | Frame clock at the sample rate, rises with the first bit |
| bit_clk | output | 1 | Bit clock at half the fast rate, data on both edges |

## Verification
The bench builds the block with its defaults: four lanes and 12-bit words. With these values the frame is twelve slots, which divides into six bit-clock periods, and four lanes are enough to show that words cannot cross from one lane to another. The bench places strobes, order flips and a mid-stream reset at chosen slots: the last slot of a word, the middle of a word and two strobes within one word. It then checks each reassembled word against the latest-wins and boundary-sampling rules.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

    localparam int DEF_LANES  = 4;
    localparam int DEF_WORD_W = 12;

    typedef enum logic {
        ORD_LSB = 1'b0,
        ORD_MSB = 1'b1
    } order_e;

    typedef struct packed {
        logic run;
        logic boundary;
    } tick_t;

    function automatic int slot_bits(input int width);
        return (width <= 2) ? 1 : $clog2(width);
    endfunction

endpackage

// File: rtl/ser_slot_timer.sv
module ser_slot_timer
    import adc_ser_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    parameter int SW     = slot_bits(DEF_WORD_W)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [SW-1:0] slot,
    output tick_t         tick,
    output logic          frame_clk,
    output logic          bit_clk
);
    localparam logic [SW-1:0] LAST_SLOT = SW'(WORD_W - 1);
    localparam logic [SW-1:0] HALF_SLOT = SW'(WORD_W / 2);

    logic [SW-1:0] slot_q;
    logic          run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= LAST_SLOT;
            run_q  <= 1'b0;
        end else begin
            run_q  <= 1'b1;
            slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
        end
    end

    always_comb begin
        tick.run      = run_q;
        tick.boundary = (slot_q == LAST_SLOT);
        slot          = slot_q;
        frame_clk     = run_q && (slot_q < HALF_SLOT);
        bit_clk       = run_q && !slot_q[0];
    end

endmodule

// File: rtl/ser_lane_unit.sv
module ser_lane_unit
    import adc_ser_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    parameter int SW     = slot_bits(DEF_WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [WORD_W-1:0] din,
    input  logic              load,
    input  order_e            ord,
    input  logic [SW-1:0]     slot,
    output logic              dout
);
    localparam logic [SW-1:0] TOP_IDX = SW'(WORD_W - 1);

    logic [WORD_W-1:0] held_q;
    logic [WORD_W-1:0] cur_q;
    logic [WORD_W-1:0] held_nx;
    logic [SW-1:0]     idx;

    assign held_nx = take ? din : held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            cur_q  <= '0;
        end else begin
            held_q <= held_nx;
            if (load) begin
                cur_q <= held_nx;
            end
        end
    end

    always_comb begin
        idx  = (ord == ORD_MSB) ? (TOP_IDX - slot) : slot;
        dout = cur_q[idx];
    end

endmodule

// File: rtl/adc_word_serializer.sv
module adc_word_serializer
    import adc_ser_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [LANES*WORD_W-1:0] in_words,
    input  logic                    msb_first,
    output logic [LANES-1:0]        lane_out,
    output logic                    frame_clk,
    output logic                    bit_clk
);
    localparam int SW = slot_bits(WORD_W);

    logic [SW-1:0] slot_w;
    tick_t         tick_w;
    order_e        ord_q;
    logic          run_w;

    assign run_w = tick_w.run;

    ser_slot_timer #(.WORD_W(WORD_W), .SW(SW)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot_w),
        .tick      (tick_w),
        .frame_clk (frame_clk),
        .bit_clk   (bit_clk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ord_q <= ORD_MSB;
        end else if (tick_w.boundary) begin
            ord_q <= msb_first ? ORD_MSB : ORD_LSB;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ser_lane_unit #(.WORD_W(WORD_W), .SW(SW)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .take (in_valid),
            .din  (in_words[g*WORD_W +: WORD_W]),
            .load (tick_w.boundary),
            .ord  (ord_q),
            .slot (slot_w),
            .dout (lane_out[g])
        );
    end

endmodule

// File: rtl/adc_word_serializer_chk.sv
module adc_word_serializer_chk #(
    parameter int LANES  = 4,
    parameter int WORD_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic [LANES-1:0] lane_out,
    input logic             frame_clk,
    input logic             bit_clk
);
    logic [15:0] gap_q;
    logic [15:0] high_q;
    logic        prev_f_q;
    logic        seen_q;
    logic        rise_w;

    assign rise_w = frame_clk && !prev_f_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q    <= '0;
            high_q   <= '0;
            prev_f_q <= 1'b0;
            seen_q   <= 1'b0;
        end else begin
            prev_f_q <= frame_clk;
            gap_q    <= rise_w ? 16'd1 : gap_q + 16'd1;
            seen_q   <= seen_q | rise_w;
            high_q   <= frame_clk ? high_q + 16'd1 : 16'd0;
        end
    end

    AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (rise_w && seen_q) |-> (gap_q == 16'(WORD_W))); // R1

    AST_FRAME_HIGH_HALF: assert property (@(posedge clk) disable iff (rst)
        (!frame_clk && prev_f_q) |-> (high_q == 16'(WORD_W / 2))); // R1

    AST_BIT_CLK_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> (bit_clk != $past(bit_clk))); // R2

    AST_FIRST_BIT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        rise_w |-> bit_clk); // R3

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (lane_out == '0 && !frame_clk && !bit_clk)); // R9

endmodule

bind adc_word_serializer adc_word_serializer_chk #(
    .LANES  (LANES),
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (run_w),
    .lane_out  (lane_out),
    .frame_clk (frame_clk),
    .bit_clk   (bit_clk)
);

// File: tb/test_adc_word_serializer.sv
module test_adc_word_serializer;
    localparam int NL = 4;
    localparam int WW = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [NL*WW-1:0] in_words = '0;
    logic             msb_first = 1'b1;
    logic [NL-1:0]    lane_out;
    logic             frame_clk;
    logic             bit_clk;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    adc_word_serializer i_adc_word_serializer (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_words  (in_words),
        .msb_first (msb_first),
        .lane_out  (lane_out),
        .frame_clk (frame_clk),
        .bit_clk   (bit_clk)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int          m_slot = WW - 1;
    bit          m_live = 0;
    bit          m_msb  = 1;
    bit          m_ok   = 0;
    logic [WW-1:0] m_held [NL];
    logic [WW-1:0] m_cur  [NL];

    always @(posedge clk) begin
        logic [WW-1:0] nh [NL];
        m_ok = 1;
        if (rst) begin
            m_slot = WW - 1;
            m_live = 0;
            m_msb  = 1;
            for (int l = 0; l < NL; l++) begin
                m_held[l] = '0;
                m_cur[l]  = '0;
            end
        end else begin
            for (int l = 0; l < NL; l++)
                nh[l] = in_valid ? in_words[l*WW +: WW] : m_held[l];
            if (m_slot == WW - 1) begin
                for (int l = 0; l < NL; l++) m_cur[l] = nh[l];
                m_msb  = msb_first;
                m_slot = 0;
            end else begin
                m_slot++;
            end
            for (int l = 0; l < NL; l++) m_held[l] = nh[l];
            m_live = 1;
        end
    end

    always @(negedge clk) begin
        logic [NL-1:0] exp_l;
        logic          exp_f;
        logic          exp_b;
        if (m_ok) begin
            for (int l = 0; l < NL; l++)
                exp_l[l] = m_cur[l][m_msb ? (WW - 1 - m_slot) : m_slot];
            exp_f = m_live && (m_slot < WW / 2);
            exp_b = m_live && (m_slot % 2 == 0);
            chk(lane_out === exp_l, m_msb ? "R4 lanes" : "R5 lanes", 64'(lane_out), 64'(exp_l));
            chk(frame_clk === exp_f, "R1 frame", 64'(frame_clk), 64'(exp_f));
            chk(bit_clk === exp_b, "R2 bitclk", 64'(bit_clk), 64'(exp_b));
        end
    end

    task automatic pulse(input logic [NL*WW-1:0] w);
        in_words = w;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // waits for the next frame rise, then reads one word from every lane
    task automatic run_word(input bit inj, input logic [NL*WW-1:0] iw, input bit flip,
                            input bit as_msb, output logic [NL*WW-1:0] got);
        logic prevf;
        prevf = frame_clk;
        forever begin
            @(negedge clk);
            if (frame_clk && !prevf) break;
            prevf = frame_clk;
        end
        got = '0;
        for (int k = 0; k < WW; k++) begin
            if (k > 0) @(negedge clk);
            for (int l = 0; l < NL; l++) begin
                if (as_msb) got[l*WW + WW - 1 - k] = lane_out[l];
                else        got[l*WW + k]          = lane_out[l];
            end
            in_valid = inj && (k == 6);
            if (inj && k == 6) in_words = iw;
            if (flip && k == 3) msb_first = ~msb_first;
        end
    endtask

    localparam logic [NL*WW-1:0] WA = {12'h5A3, 12'hC0F, 12'h801, 12'hFFE};
    localparam logic [NL*WW-1:0] WB = {12'h123, 12'h456, 12'h789, 12'hABC};
    localparam logic [NL*WW-1:0] WC = {12'h0F1, 12'hE2D, 12'h3C4, 12'hB5A};
    localparam logic [NL*WW-1:0] WD = {12'h111, 12'h222, 12'h333, 12'h444};
    localparam logic [NL*WW-1:0] WE = {12'h9A7, 12'h06B, 12'hD48, 12'h27F};
    localparam logic [NL*WW-1:0] WF = {12'hF00, 12'h00F, 12'h0F0, 12'h801};

    initial begin
        logic [NL*WW-1:0] got;
        repeat (4) @(negedge clk);
        chk(lane_out == '0 && !frame_clk && !bit_clk, "R9 in reset",
            64'({lane_out, frame_clk, bit_clk}), 64'(0));
        rst = 1'b0;
        chk(lane_out == '0 && !frame_clk && !bit_clk, "R9 first cycle after reset",
            64'({lane_out, frame_clk, bit_clk}), 64'(0));
        @(negedge clk);
        chk(frame_clk && bit_clk, "R3 R9 word starts after reset",
            64'({frame_clk, bit_clk}), 64'(3));

        pulse(WA);
        run_word(0, '0, 0, 1, got);
        chk(got == WA, "R4 R10 msb-first word", got, WA);
        run_word(0, '0, 0, 1, got);
        chk(got == WA, "R8 repeat without strobe", got, WA);

        msb_first = 1'b0;
        pulse(WB);
        run_word(0, '0, 0, 0, got);
        chk(got == WB, "R5 R10 lsb-first word", got, WB);

        run_word(1, WC, 0, 0, got);
        chk(got == WB, "R7 mid-word strobe leaves word", got, WB);
        run_word(0, '0, 1, 0, got);
        chk(got == WC, "R7 strobe used at next word", got, WC);
        chk(msb_first == 1'b1, "R6 order flipped during word", 64'(msb_first), 64'(1));
        run_word(0, '0, 0, 1, got);
        chk(got == WC, "R6 new order from next word", got, WC);

        @(negedge clk);
        @(negedge clk);
        pulse(WD);
        @(negedge clk);
        pulse(WE);
        run_word(0, '0, 0, 1, got);
        chk(got == WE, "R7 latest strobe wins", got, WE);

        in_words = WF;
        in_valid = 1'b1;
        run_word(0, '0, 0, 1, got);
        chk(got == WF, "R7 strobe in last slot", got, WF);

        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(lane_out == '0 && !frame_clk && !bit_clk, "R9 mid-stream reset",
            64'({lane_out, frame_clk, bit_clk}), 64'(0));
        rst = 1'b0;
        run_word(0, '0, 0, 1, got);
        chk(got == '0, "R9 words cleared by reset", got, 64'(0));

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule